// File: doc/BRIEF.md
# Serial DAC Write Controller

This block is the host-side master for a three-wire serial link to a current-output DAC. A client hands it one parallel code word through a valid/ready handshake. The controller then pulls chip select low and sends a fixed-length frame, most significant bit first, with one bit per rising edge of the serial clock. After the last bit it drives chip select high again, and that rising edge is what loads the word into the converter.

The serial clock rests low. Serial data moves only on the falling edge of the serial clock, so every bit stays put for a whole high phase and a whole low phase around each rising edge. Four configuration inputs give, in system clock cycles, the chip-select setup, the serial clock half period, the chip-select hold and the minimum chip-select high gap. A code narrower than the frame is padded with leading zeros, so it lands in the trailing bit positions that the converter keeps.

Top module: `dac_serial_writer`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `dac_cs_n` is 1, `dac_sclk` is 0, `in_ready` is 1 and `done` is 0.
- R2: `in_ready` is 1 only while the link is idle with chip select high. A word is taken only in a cycle where `in_valid` and `in_ready` are both 1. Changes on `in_code` or `in_valid` while `in_ready` is 0 have no effect on the frame being sent and start no extra frame.
- R3: Each frame has exactly FRAME_W rising edges of `dac_sclk`, and all of them occur while `dac_cs_n` is 0.
- R4: The frame holds FRAME_W−CODE_W zero bits followed by the accepted code, and `dac_sdo` sends it most significant bit first. With CODE_W=14 this is two zeros, then code bit 13 down to bit 0.
- R5: `dac_cs_n` is low for exactly `cfg_setup`+1 system cycles before the first rising edge of `dac_sclk`.
- R6: Each high phase of `dac_sclk` lasts exactly `cfg_half`+1 system cycles. Each low phase between two bits of a frame also lasts exactly `cfg_half`+1 system cycles.
- R7: `dac_sdo` does not change in the cycle `dac_sclk` rises, nor while `dac_sclk` is high.
- R8: After the last falling edge of `dac_sclk`, `dac_cs_n` stays low for exactly `cfg_hold`+1 cycles. `dac_sclk` is low in the cycle before and in the cycle of the chip-select rise.
- R9: After `dac_cs_n` rises, `in_ready` stays 0 for exactly `cfg_gap`+1 cycles, so consecutive frames are separated by a chip-select high gap.
- R10: `done` is 1 for exactly one cycle, which is the first cycle of chip select high after a frame.
- R11: `dac_sclk` is 0 whenever `dac_cs_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A code word is offered |
| in_ready | output | 1 | The controller can accept a word |
| in_code | input | CODE_W | Code word to send |
| cfg_setup | input | CNT_W | Chip-select setup, in cycles minus one |
| cfg_half | input | CNT_W | Serial clock phase length, in cycles minus one |
| cfg_hold | input | CNT_W | Chip-select hold, in cycles minus one |
| cfg_gap | input | CNT_W | Minimum chip-select high gap, in cycles minus one |
| dac_cs_n | output | 1 | Chip select to the converter, active low |
| dac_sclk | output | 1 | Serial clock to the converter, rests low |
| dac_sdo | output | 1 | Serial data to the converter |
| done | output | 1 | One-cycle pulse after the load strobe |

## Verification
The checker evaluates the edge-level relations every cycle:
- the serial clock is quiet whenever chip select is high and around the chip-select rise;
- data is stable across each high phase;
- every frame has exactly FRAME_W rising edges;
- `done` is a single-cycle pulse;
- `in_ready` is only seen with chip select high.

The bench scenarios cover the parts that depend on the configured counts or on the content of a frame:
- the exact setup, phase, hold and gap lengths under randomly chosen settings;
- the bits captured at each rising edge, including the zero padding;
- back-to-back frames;
- input activity that must be ignored while a frame is in flight.

// File: rtl/dsw_pkg.sv
// Shared types for the serial DAC write controller.
// Assumes nothing beyond a synthesizable enum encoding.
package dsw_pkg;

    // Controller phases in the order a frame walks through them
    typedef enum logic [2:0] {
        DSW_IDLE     = 3'd0,
        DSW_CS_SETUP = 3'd1,
        DSW_SHIFT    = 3'd2,
        DSW_CS_HOLD  = 3'd3,
        DSW_CS_GAP   = 3'd4
    } dsw_state_e;

endpackage

// File: rtl/dsw_interval_timer.sv
// Down-counter that measures one programmable interval at a time.
// After a load with value N, `expired` is high in the (N+1)-th cycle.
// Assumes the caller reloads it at every phase change.
module dsw_interval_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] remain_q;

    // Load a new interval, or count the current one down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_val;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign expired = (remain_q == '0);

endmodule

// File: rtl/dsw_frame_shifter.sv
// Frame register that presents its most significant bit on the serial line.
// A load captures a full frame; a shift moves the next bit into the top position.
// Assumes load and shift are never requested in the same cycle.
module dsw_frame_shifter #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               shift,
    input  logic [FRAME_W-1:0] frame_in,
    output logic               bit_out
);

    logic [FRAME_W-1:0] frame_q;

    // Capture a new frame or advance it by one bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (load) begin
            frame_q <= frame_in;
        end else if (shift) begin
            frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
        end
    end

    assign bit_out = frame_q[FRAME_W-1];

endmodule

// File: rtl/dac_serial_writer.sv
// Host-side master for a three-wire serial DAC link.
// It accepts one code per valid/ready handshake and sends it as a FRAME_W-bit
// frame, MSB first. Leading zeros pad a code narrower than the frame.
// The serial clock rests low. Data changes only when the serial clock falls.
// Chip select rises only once the serial clock has been quiet for the hold count.
// Assumes the cfg_* inputs are held stable while a frame is in progress.
module dac_serial_writer #(
    parameter int CODE_W  = 16,
    parameter int FRAME_W = 16,
    parameter int CNT_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CODE_W-1:0] in_code,
    input  logic [CNT_W-1:0]  cfg_setup,
    input  logic [CNT_W-1:0]  cfg_half,
    input  logic [CNT_W-1:0]  cfg_hold,
    input  logic [CNT_W-1:0]  cfg_gap,
    output logic              dac_cs_n,
    output logic              dac_sclk,
    output logic              dac_sdo,
    output logic              done
);

    import dsw_pkg::*;

    localparam int BIT_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
    localparam int PAD_W = FRAME_W - CODE_W;
    localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(FRAME_W - 1);

    dsw_state_e       state_q, state_d;
    logic             cs_n_q, cs_n_d;
    logic             sclk_q, sclk_d;
    logic             done_q, done_d;
    logic [BIT_W-1:0] bit_q, bit_d;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             sh_load;
    logic             sh_shift;
    logic [FRAME_W-1:0] frame_word;

    // Build the outgoing frame; a narrow code gets leading zero padding
    generate
        if (PAD_W > 0) begin : g_pad
            assign frame_word = {{PAD_W{1'b0}}, in_code};
        end else begin : g_full
            assign frame_word = in_code[FRAME_W-1:0];
        end
    endgenerate

    dsw_interval_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    dsw_frame_shifter #(
        .FRAME_W(FRAME_W)
    ) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .shift    (sh_shift),
        .frame_in (frame_word),
        .bit_out  (dac_sdo)
    );

    // Next-state and next-output decode for the frame sequence
    always_comb begin
        state_d  = state_q;
        cs_n_d   = cs_n_q;
        sclk_d   = sclk_q;
        done_d   = 1'b0;
        bit_d    = bit_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (state_q)
            DSW_IDLE: begin
                cs_n_d = 1'b1;
                sclk_d = 1'b0;
                if (in_valid) begin
                    state_d  = DSW_CS_SETUP;
                    cs_n_d   = 1'b0;
                    sh_load  = 1'b1;
                    bit_d    = LAST_IDX;
                    tmr_load = 1'b1;
                    tmr_val  = cfg_setup;
                end
            end
            DSW_CS_SETUP: begin
                if (tmr_expired) begin
                    state_d  = DSW_SHIFT;
                    sclk_d   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = cfg_half;
                end
            end
            DSW_SHIFT: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    if (sclk_q) begin
                        sclk_d = 1'b0;
                        if (bit_q == '0) begin
                            state_d = DSW_CS_HOLD;
                            tmr_val = cfg_hold;
                        end else begin
                            sh_shift = 1'b1;
                            bit_d    = bit_q - 1'b1;
                            tmr_val  = cfg_half;
                        end
                    end else begin
                        sclk_d  = 1'b1;
                        tmr_val = cfg_half;
                    end
                end
            end
            DSW_CS_HOLD: begin
                if (tmr_expired) begin
                    state_d  = DSW_CS_GAP;
                    cs_n_d   = 1'b1;
                    done_d   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = cfg_gap;
                end
            end
            DSW_CS_GAP: begin
                if (tmr_expired) begin
                    state_d = DSW_IDLE;
                end
            end
            default: begin
                state_d = DSW_IDLE;
                cs_n_d  = 1'b1;
                sclk_d  = 1'b0;
            end
        endcase
    end

    // Register the phase, the link pins and the bit index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DSW_IDLE;
            cs_n_q  <= 1'b1;
            sclk_q  <= 1'b0;
            done_q  <= 1'b0;
            bit_q   <= '0;
        end else begin
            state_q <= state_d;
            cs_n_q  <= cs_n_d;
            sclk_q  <= sclk_d;
            done_q  <= done_d;
            bit_q   <= bit_d;
        end
    end

    assign in_ready = (state_q == DSW_IDLE);
    assign dac_cs_n = cs_n_q;
    assign dac_sclk = sclk_q;
    assign done     = done_q;

endmodule

// File: rtl/dsw_checker.sv
// Cycle-level protocol checks on the serial DAC link, bound to the top module.
// Assumes synchronous active-low reset and registered link outputs.
module dsw_checker #(
    parameter int FRAME_W = 16
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic sdo,
    input logic ready,
    input logic done
);

    localparam int EC_W = $clog2(FRAME_W + 1) + 1;

    logic [EC_W-1:0] edge_cnt_q;
    logic            cs_prev_q;
    logic            sclk_prev_q;

    // Count rising serial clock edges since chip select last fell
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_cnt_q  <= '0;
            cs_prev_q   <= 1'b1;
            sclk_prev_q <= 1'b0;
        end else begin
            cs_prev_q   <= cs_n;
            sclk_prev_q <= sclk;
            if (cs_prev_q && !cs_n) begin
                edge_cnt_q <= '0;
            end else if (!sclk_prev_q && sclk) begin
                edge_cnt_q <= edge_cnt_q + 1'b1;
            end
        end
    end

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk); // R11

    AST_SDO_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(sdo)); // R7

    AST_CS_RISE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (!sclk && !$past(sclk))); // R8

    AST_EDGE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (edge_cnt_q == EC_W'(FRAME_W))); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_DONE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $rose(cs_n)); // R10

    AST_READY_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> cs_n); // R2

endmodule

bind dac_serial_writer dsw_checker #(.FRAME_W(FRAME_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (dac_cs_n),
    .sclk  (dac_sclk),
    .sdo   (dac_sdo),
    .ready (in_ready),
    .done  (done)
);

// File: tb/dac_serial_writer_tb.sv
module dac_serial_writer_tb;

    localparam int CW = 14;
    localparam int FW = 16;
    localparam int NW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [CW-1:0] in_code = '0;
    logic [NW-1:0] cfg_setup = '0, cfg_half = '0, cfg_hold = '0, cfg_gap = '0;
    logic          dac_cs_n, dac_sclk, dac_sdo, done;

    int total = 0;
    int bad = 0;
    bit mon_on = 0;
    bit finished = 0;

    logic [FW-1:0] exp_q[$];

    always #5 clk = ~clk;

    dac_serial_writer #(.CODE_W(CW), .FRAME_W(FW), .CNT_W(NW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_code(in_code), .cfg_setup(cfg_setup), .cfg_half(cfg_half),
        .cfg_hold(cfg_hold), .cfg_gap(cfg_gap), .dac_cs_n(dac_cs_n),
        .dac_sclk(dac_sclk), .dac_sdo(dac_sdo), .done(done)
    );

    // Expected frame for R4: leading zero padding, then the code
    function automatic logic [FW-1:0] exp_frame(input logic [CW-1:0] c);
        return {{(FW-CW){1'b0}}, c};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Link monitor: samples at the falling system edge and measures every phase
    logic pc = 1'b1, ps = 1'b0;
    int run = 0, nrise = 0, gap_run = 0;
    bit in_gap = 0, chk_done_next = 0;
    logic [FW-1:0] cap = '0;

    always @(negedge clk) begin
        if (mon_on) begin
            if (chk_done_next) begin
                check(done == 1'b0, "R10 done width", done, 0);
                chk_done_next = 0;
            end
            check(!(dac_cs_n && dac_sclk), "R11 sclk idle", dac_sclk, 0);
            if (!dac_cs_n) check(!in_ready, "R2 ready in frame", in_ready, 0);
            if ({dac_cs_n, dac_sclk} != {pc, ps}) begin
                if (!pc && !ps && dac_sclk && nrise == 0)
                    check(run == cfg_setup + 1, "R5 cs setup", run, cfg_setup + 1);
                else if (!pc && !ps && dac_sclk)
                    check(run == cfg_half + 1, "R6 low phase", run, cfg_half + 1);
                else if (!pc && ps)
                    check(run == cfg_half + 1, "R6 high phase", run, cfg_half + 1);
                else if (!pc && !ps && dac_cs_n) begin
                    check(run == cfg_hold + 1, "R8 cs hold", run, cfg_hold + 1);
                    check(nrise == FW, "R3 edge count", nrise, FW);
                    if (exp_q.size() == 0) begin
                        check(0, "R2 unexpected frame", cap, 0);
                    end else begin
                        logic [FW-1:0] e;
                        e = exp_q.pop_front();
                        check(cap == e, "R4 frame bits", cap, e);
                    end
                    check(done == 1'b1, "R10 done at cs rise", done, 1);
                    chk_done_next = 1;
                    in_gap = 1;
                    gap_run = 0;
                end
                if (pc && !dac_cs_n) begin
                    nrise = 0;
                    cap = '0;
                end
                run = 1;
            end else begin
                run++;
            end
            if (dac_sclk && !ps) begin
                nrise++;
                cap = {cap[FW-2:0], dac_sdo};
            end
            if (in_gap) begin
                if (in_ready) begin
                    check(gap_run == cfg_gap + 1, "R9 cs gap", gap_run, cfg_gap + 1);
                    in_gap = 0;
                end else begin
                    gap_run++;
                end
            end
            pc = dac_cs_n;
            ps = dac_sclk;
        end
    end

    // Offer one code; called at a falling edge; optionally keep valid high after
    task automatic send(input logic [CW-1:0] c, input bit keep);
        in_code = c;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        exp_q.push_back(exp_frame(c));
        @(negedge clk);
        if (!keep) in_valid = 1'b0;
    endtask

    task automatic wait_quiet();
        @(negedge clk);
        while (exp_q.size() != 0 || in_gap || !in_ready || !dac_cs_n) @(negedge clk);
    endtask

    task automatic set_cfg(input int s, input int h, input int d, input int g);
        cfg_setup = NW'(s);
        cfg_half  = NW'(h);
        cfg_hold  = NW'(d);
        cfg_gap   = NW'(g);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1: values during reset
        check(dac_cs_n == 1 && dac_sclk == 0 && done == 0, "R1 in reset", {dac_cs_n, dac_sclk, done}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        check(dac_cs_n == 1 && dac_sclk == 0 && in_ready == 1 && done == 0,
              "R1 after reset", {dac_cs_n, dac_sclk, in_ready, done}, 4'b1010);
        mon_on = 1;

        // Directed: tightest timing, all ones and all zeros (R3 R4 R5 R6 R8)
        set_cfg(0, 0, 0, 0);
        send(14'h3FFF, 0);
        wait_quiet();
        send(14'h0000, 0);
        wait_quiet();

        // Directed: longer intervals with an alternating pattern
        set_cfg(3, 2, 4, 5);
        send(14'h2AAA, 0);
        wait_quiet();
        send(14'h1555, 0);
        wait_quiet();

        // Directed: back-to-back frames with valid held high (R9)
        set_cfg(1, 1, 1, 2);
        send(14'h2001, 1);
        send(14'h0FF0, 0);
        wait_quiet();

        // Directed: input activity while busy must be ignored (R2)
        set_cfg(2, 1, 0, 1);
        send(14'h1234, 0);
        while (dac_cs_n) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            in_code = CW'($urandom);
            in_valid = 1'b1;
            check(in_ready == 1'b0, "R2 ready low while busy", in_ready, 0);
            @(negedge clk);
        end
        in_valid = 1'b0;
        wait_quiet();

        // Constrained random frames and settings
        for (int n = 0; n < 30; n++) begin
            set_cfg($urandom_range(0, 4), $urandom_range(0, 3),
                    $urandom_range(0, 4), $urandom_range(0, 4));
            send(CW'($urandom), ($urandom_range(0, 3) == 0));
            if (in_valid) send(CW'($urandom), 0);
            wait_quiet();
        end

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R3 all frames sent", exp_q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule